// File: doc/BRIEF.md
# Clock Source Mode Controller

This block picks the reference that drives the master clock outputs of an audio receiver: the clock recovered by the receiver PLL, or the local crystal oscillator. From the same decision it picks the input that feeds the serial data output: receiver data or the auxiliary input. A 2-bit mode field sets the policy. One mode switches to the crystal on its own when the PLL loses lock. The block does not switch clocks itself. It drives registered select and enable levels for the glitch-free muxes and clock gates that sit downstream.

The block also sets two master clock outputs. For each one it returns a ratio code (64fs, 128fs, 256fs, 512fs or off) and an enable. The code comes from a 2-bit rate-select field through a fixed lookup. Any ratio that would be too fast at the current sample-rate class is then forced off.

The raw PLL lock input first goes through a stability filter of `LOCK_FILT_CYCLES` reference cycles. The lock indication can chatter when the incoming sync interval is irregular, and the filter keeps that chatter from reaching the source select.

Top module: `mclk_source_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, the outputs are `src_is_xtal`=1, `sdo_from_aux`=1, `pll_enable`=0, both ratio codes 0 (off) and both enables 0. The filtered lock state resets to unlocked.
- R2: Mode 0 (`mode_sel`=0) gives `src_is_xtal`=0, `sdo_from_aux`=0 and `pll_enable`=1, whatever the lock input is. Every routing and ratio output is registered and follows its inputs one clock later.
- R3: Mode 1 gives `src_is_xtal`=1, `sdo_from_aux`=1 and `pll_enable`=0.
- R4: Mode 3 gives `src_is_xtal`=1 and `sdo_from_aux`=1 with `pll_enable`=1, so recovered status data can still be monitored.
- R5: Mode 2 gives `pll_enable`=1. While the filtered lock is 1 it gives `src_is_xtal`=0 and `sdo_from_aux`=0. While the filtered lock is 0 it gives 1 for both. In this mode `sdo_from_aux` always equals `src_is_xtal`.
- R6: The filtered lock takes the value of `pll_locked` only after `pll_locked` has differed from it for `LOCK_FILT_CYCLES` consecutive clocks. The routing outputs show the change one clock after that. A shorter pulse on `pll_locked` has no effect.
- R7: Ratio codes are 0=off, 1=64fs, 2=128fs, 3=256fs and 4=512fs. Before suppression, `rate_sel` 0/1/2/3 maps output 1 to 256/256/512/128fs and output 2 to 256/128/256/64fs.
- R8: `fs_class` is coded 0 = up to 48 kHz, 1 = 88.2/96 kHz, 2 or 3 = 176.4/192 kHz. A 512fs ratio is forced to off when `fs_class` is not 0.
- R9: A 256fs ratio is forced to off when `fs_class` is 2 or 3.
- R10: Each `mckN_en` is 1 exactly when its `mckN_code` is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Clock operation mode 0..3 |
| pll_locked | input | 1 | Raw PLL lock indication |
| rate_sel | input | 2 | Master clock ratio select |
| fs_class | input | 2 | Detected sample-rate class |
| src_is_xtal | output | 1 | 1 = crystal drives the master clocks, 0 = PLL |
| sdo_from_aux | output | 1 | 1 = auxiliary input on the serial output, 0 = receiver data |
| pll_enable | output | 1 | PLL kept running |
| mck1_code | output | 3 | Ratio code of master clock output 1 |
| mck1_en | output | 1 | Enable of master clock output 1 |
| mck2_code | output | 3 | Ratio code of master clock output 2 |
| mck2_en | output | 1 | Enable of master clock output 2 |

## Verification
The bench holds `pll_locked` at a new level for exactly `LOCK_FILT_CYCLES` clocks and checks the routing one clock before and one clock after it should switch. A filter that is off by one cycle therefore shows up. It also sends a pulse that is one cycle too short, which a filter without a counter reset would let through and switch to the PLL. In every mode it drives the lock input against the expected answer, so a design that lets lock affect modes 0, 1 or 3, or that drops the data-source follow in mode 2, gives a wrong select. It sweeps every rate-select against every rate class, so a design that suppresses on the wrong class boundary, or treats class 3 as a slow rate, enables a ratio that is too fast.

// File: rtl/mclk_src_pkg.sv
package mclk_src_pkg;

    localparam int NUM_MCK = 2;
    localparam int CODE_W  = 3;

    typedef enum logic [2:0] {
        RATIO_OFF = 3'd0,
        RATIO_64  = 3'd1,
        RATIO_128 = 3'd2,
        RATIO_256 = 3'd3,
        RATIO_512 = 3'd4
    } ratio_e;

    typedef enum logic [1:0] {
        FS_BASE   = 2'd0,
        FS_DOUBLE = 2'd1,
        FS_QUAD   = 2'd2,
        FS_QUAD_X = 2'd3
    } fs_class_e;

    typedef enum logic [1:0] {
        MODE_RECOVERED = 2'd0,
        MODE_CRYSTAL   = 2'd1,
        MODE_AUTO      = 2'd2,
        MODE_MONITOR   = 2'd3
    } clk_mode_e;

    typedef struct packed {
        logic src_xtal;
        logic sdo_aux;
        logic pll_en;
    } route_t;

    localparam route_t ROUTE_RESET = '{src_xtal: 1'b1, sdo_aux: 1'b1, pll_en: 1'b0};

    // Ratio a given output asks for before any rate-class suppression.
    function automatic ratio_e base_ratio(input int idx, input logic [1:0] rs);
        ratio_e r;
        if (idx == 0) begin
            case (rs)
                2'd0:    r = RATIO_256;
                2'd1:    r = RATIO_256;
                2'd2:    r = RATIO_512;
                default: r = RATIO_128;
            endcase
        end else begin
            case (rs)
                2'd0:    r = RATIO_256;
                2'd1:    r = RATIO_128;
                2'd2:    r = RATIO_256;
                default: r = RATIO_64;
            endcase
        end
        return r;
    endfunction

    // Force ratios that are too fast for the current sample-rate class to off.
    function automatic ratio_e gate_ratio(input ratio_e r, input fs_class_e c);
        ratio_e g;
        g = r;
        if (r == RATIO_512 && c != FS_BASE)
            g = RATIO_OFF;
        if (r == RATIO_256 && (c == FS_QUAD || c == FS_QUAD_X))
            g = RATIO_OFF;
        return g;
    endfunction

endpackage

// File: rtl/mclk_lock_filter.sv
module mclk_lock_filter #(
    parameter int FILT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_lock,
    output logic filt_lock
);
    localparam int CNT_W = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_lock <= 1'b0;
            run_cnt   <= '0;
        end else if (raw_lock == filt_lock) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            filt_lock <= raw_lock;
            run_cnt   <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mclk_route_decode.sv
module mclk_route_decode
    import mclk_src_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       lock_ok,
    output route_t     route
);
    clk_mode_e mode;
    assign mode = clk_mode_e'(mode_sel);

    always_comb begin
        route = ROUTE_RESET;
        case (mode)
            MODE_RECOVERED: route = '{src_xtal: 1'b0, sdo_aux: 1'b0, pll_en: 1'b1};
            MODE_CRYSTAL:   route = '{src_xtal: 1'b1, sdo_aux: 1'b1, pll_en: 1'b0};
            MODE_AUTO: begin
                route.pll_en   = 1'b1;
                route.src_xtal = ~lock_ok;
                route.sdo_aux  = ~lock_ok;
            end
            MODE_MONITOR:   route = '{src_xtal: 1'b1, sdo_aux: 1'b1, pll_en: 1'b1};
            default:        route = ROUTE_RESET;
        endcase
    end
endmodule

// File: rtl/mclk_ratio_gate.sv
module mclk_ratio_gate
    import mclk_src_pkg::*;
#(
    parameter int OUT_IDX = 0
) (
    input  logic [1:0] rate_sel,
    input  logic [1:0] fs_class,
    output ratio_e     code,
    output logic       en
);
    ratio_e raw_code;

    always_comb begin
        raw_code = base_ratio(OUT_IDX, rate_sel);
        code     = gate_ratio(raw_code, fs_class_e'(fs_class));
        en       = (code != RATIO_OFF);
    end
endmodule

// File: rtl/mclk_source_ctrl.sv
module mclk_source_ctrl
    import mclk_src_pkg::*;
#(
    parameter int LOCK_FILT_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       pll_locked,
    input  logic [1:0] rate_sel,
    input  logic [1:0] fs_class,
    output logic       src_is_xtal,
    output logic       sdo_from_aux,
    output logic       pll_enable,
    output logic [2:0] mck1_code,
    output logic       mck1_en,
    output logic [2:0] mck2_code,
    output logic       mck2_en
);
    logic   lock_filt;
    route_t route_c;
    route_t route_q;
    ratio_e code_c [NUM_MCK];
    logic   en_c   [NUM_MCK];
    ratio_e code_q [NUM_MCK];
    logic   en_q   [NUM_MCK];

    mclk_lock_filter #(.FILT_CYCLES(LOCK_FILT_CYCLES)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .raw_lock  (pll_locked),
        .filt_lock (lock_filt)
    );

    mclk_route_decode u_route (
        .mode_sel (mode_sel),
        .lock_ok  (lock_filt),
        .route    (route_c)
    );

    for (genvar g = 0; g < NUM_MCK; g++) begin : g_mck
        mclk_ratio_gate #(.OUT_IDX(g)) u_gate (
            .rate_sel (rate_sel),
            .fs_class (fs_class),
            .code     (code_c[g]),
            .en       (en_c[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[g] <= RATIO_OFF;
                en_q[g]   <= 1'b0;
            end else begin
                code_q[g] <= code_c[g];
                en_q[g]   <= en_c[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) route_q <= ROUTE_RESET;
        else     route_q <= route_c;
    end

    assign src_is_xtal  = route_q.src_xtal;
    assign sdo_from_aux = route_q.sdo_aux;
    assign pll_enable   = route_q.pll_en;
    assign mck1_code    = code_q[0];
    assign mck1_en      = en_q[0];
    assign mck2_code    = code_q[1];
    assign mck2_en      = en_q[1];
endmodule

// File: rtl/mclk_source_ctrl_chk.sv
module mclk_source_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic [1:0] fs_class,
    input logic       src_is_xtal,
    input logic       sdo_from_aux,
    input logic       pll_enable,
    input logic [2:0] mck1_code,
    input logic       mck1_en,
    input logic [2:0] mck2_code,
    input logic       mck2_en
);
    // R2
    mode0_route_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd0) |=> (!src_is_xtal && !sdo_from_aux && pll_enable));

    // R3
    mode1_route_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd1) |=> (src_is_xtal && sdo_from_aux && !pll_enable));

    // R4
    mode3_route_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd3) |=> (src_is_xtal && sdo_from_aux && pll_enable));

    // R5
    mode2_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd2) |=> (pll_enable && (sdo_from_aux == src_is_xtal)));

    // R8
    no_512_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (fs_class != 2'd0) |=> (mck1_code != 3'd4 && mck2_code != 3'd4));

    // R9
    no_256_quad_chk: assert property (@(posedge clk) disable iff (rst)
        (fs_class[1]) |=> (mck1_code != 3'd3 && mck2_code != 3'd3));

    // R10
    en_matches_code_chk: assert property (@(posedge clk) disable iff (rst)
        (mck1_en == (mck1_code != 3'd0)) && (mck2_en == (mck2_code != 3'd0)));
endmodule

bind mclk_source_ctrl mclk_source_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_sel     (mode_sel),
    .fs_class     (fs_class),
    .src_is_xtal  (src_is_xtal),
    .sdo_from_aux (sdo_from_aux),
    .pll_enable   (pll_enable),
    .mck1_code    (mck1_code),
    .mck1_en      (mck1_en),
    .mck2_code    (mck2_code),
    .mck2_en      (mck2_en)
);

// File: tb/mclk_source_ctrl_tb.sv
module mclk_source_ctrl_tb_top;
    localparam int FILT = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_sel;
    logic       pll_locked;
    logic [1:0] rate_sel;
    logic [1:0] fs_class;
    logic       src_is_xtal, sdo_from_aux, pll_enable;
    logic [2:0] mck1_code, mck2_code;
    logic       mck1_en, mck2_en;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    mclk_source_ctrl #(.LOCK_FILT_CYCLES(FILT)) dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .pll_locked(pll_locked),
        .rate_sel(rate_sel), .fs_class(fs_class),
        .src_is_xtal(src_is_xtal), .sdo_from_aux(sdo_from_aux), .pll_enable(pll_enable),
        .mck1_code(mck1_code), .mck1_en(mck1_en), .mck2_code(mck2_code), .mck2_en(mck2_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_route(input string req, input int x, input int a, input int p);
        chk({req, " src_is_xtal"}, int'(src_is_xtal), x);
        chk({req, " sdo_from_aux"}, int'(sdo_from_aux), a);
        chk({req, " pll_enable"}, int'(pll_enable), p);
    endtask

    function automatic int exp_ratio(input int idx, input int rs, input int fc);
        int r;
        if (idx == 0) r = (rs == 2) ? 4 : (rs == 3) ? 2 : 3;
        else          r = (rs == 1) ? 2 : (rs == 3) ? 1 : 3;
        if (r == 4 && fc != 0) r = 0;
        if (r == 3 && fc >= 2) r = 0;
        return r;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic t_reset();
        rst = 1'b1; mode_sel = 2'd0; pll_locked = 1'b1; rate_sel = 2'd2; fs_class = 2'd0;
        step(3);
        chk_route("R1 in reset", 1, 1, 0);
        chk("R1 mck1_code", int'(mck1_code), 0);
        chk("R1 mck2_code", int'(mck2_code), 0);
        chk("R1 mck1_en", int'(mck1_en), 0);
        chk("R1 mck2_en", int'(mck2_en), 0);
        rst = 1'b0;
        pll_locked = 1'b0;
        mode_sel = 2'd1;
        step(1);
        chk_route("R1 after release", 1, 1, 0);
    endtask

    task automatic t_fixed_modes();
        for (int l = 0; l < 2; l++) begin
            pll_locked = l[0];
            mode_sel = 2'd0; step(1);
            chk_route("R2 mode0", 0, 0, 1);
            mode_sel = 2'd1; step(1);
            chk_route("R3 mode1", 1, 1, 0);
            mode_sel = 2'd3; step(1);
            chk_route("R4 mode3", 1, 1, 1);
        end
    endtask

    task automatic t_auto_lock();
        rst = 1'b1; step(1); rst = 1'b0;
        mode_sel = 2'd2; pll_locked = 1'b1;
        step(1);
        chk_route("R5 mode2 unlocked", 1, 1, 1);
        step(FILT - 1);
        chk_route("R6 lock not yet applied", 1, 1, 1);
        step(1);
        chk_route("R5 R6 mode2 locked", 0, 0, 1);
        pll_locked = 1'b0;
        step(FILT);
        chk_route("R6 unlock not yet applied", 0, 0, 1);
        step(1);
        chk_route("R5 R6 mode2 fallback", 1, 1, 1);
    endtask

    task automatic t_glitch();
        pll_locked = 1'b1;
        step(FILT - 1);
        pll_locked = 1'b0;
        step(FILT + 2);
        chk_route("R6 short pulse ignored", 1, 1, 1);
        pll_locked = 1'b1;
        step(FILT - 1);
        pll_locked = 1'b0;
        step(1);
        pll_locked = 1'b1;
        step(FILT - 1);
        chk_route("R6 counter restarts", 1, 1, 1);
        step(2);
        chk_route("R6 stable lock applied", 0, 0, 1);
    endtask

    task automatic t_ratios();
        for (int fc = 0; fc < 4; fc++) begin
            for (int rs = 0; rs < 4; rs++) begin
                rate_sel = rs[1:0]; fs_class = fc[1:0];
                step(1);
                chk($sformatf("R7 R8 R9 mck1 rs=%0d fc=%0d", rs, fc), int'(mck1_code), exp_ratio(0, rs, fc));
                chk($sformatf("R7 R8 R9 mck2 rs=%0d fc=%0d", rs, fc), int'(mck2_code), exp_ratio(1, rs, fc));
                chk("R10 mck1_en", int'(mck1_en), int'(exp_ratio(0, rs, fc) != 0));
                chk("R10 mck2_en", int'(mck2_en), int'(exp_ratio(1, rs, fc) != 0));
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
                finish_run();
            end
        end
    end

    initial begin
        step(1);
        t_reset();
        t_fixed_modes();
        t_auto_lock();
        t_glitch();
        t_ratios();
        finish_run();
    end
endmodule